// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Status Flags

This block receives asynchronous serial frames on a single input line and delivers each completed word into a receive buffer register. Timing comes from an external oversampling tick that pulses sixteen times per bit period. After it sees a falling edge on the line, the receiver confirms the start bit at mid-bit. It then collects 7 or 8 data bits, least significant first, and an optional even or odd parity bit. Finally it checks one or two stop bits.

The status set consists of a buffer-full flag and parity, framing, overrun and summary error flags. The buffer-full flag and a one-cycle interrupt pulse come up in the middle of the first stop bit. The error flags are evaluated at that same moment. They stay set until software writes the status register or drops receive enable. On overrun the arriving word is discarded and the buffer keeps its earlier word. A later buffer read returns the old word and does not recover the lost one.

Top module: `uart_rx_status`

## Requirements
- R1: While idle with both enables high, a 1-to-0 change on the synchronised line starts a frame. The line is sampled on the 8th oversample tick of the start bit. If it reads 1 there, the receiver returns to idle without producing a word or an interrupt.
- R2: Data bits arrive least significant first, and each bit is sampled on the 8th of its 16 ticks. With `cfg_seven`=1 seven bits are taken and `buf_data[7]` reads 0. With `cfg_seven`=0 eight bits are taken. With `cfg_par_en`=1 a parity bit follows the data. With `cfg_two_stop`=1 a second stop bit follows the first.
- R3: On the mid-point sample of the first stop bit, a word that is accepted is written to `buf_data`. In that same cycle `rx_full` rises to 1 and `rx_irq` is high for exactly one clock cycle.
- R4: `par_err` sets when parity is enabled and the parity check fails. With `cfg_par_odd`=0, the data bits plus the parity bit must hold an even count of ones. With `cfg_par_odd`=1, they must hold an odd count.
- R5: `frm_err` sets when the first stop bit samples 0.
- R6: A one-cycle `rd_buf` pulse clears `rx_full` and leaves `buf_data` unchanged.
- R7: A frame may complete while `rx_full` is 1 and `rd_buf` is not asserted in that cycle. Then `ovr_err` sets and `buf_data` keeps its old word. `rx_full` stays 1 and no interrupt is raised. A later read still returns the old word.
- R8: `sum_err` is 1 exactly when any of `par_err`, `frm_err` or `ovr_err` is 1, and it rises in the same cycle as the flag that sets.
- R9: `par_err`, `frm_err` and `ovr_err` hold their value until `wr_stat` is pulsed or `rx_en` is 0. Either of those clears them on the next clock edge. Reading the buffer does not clear them.
- R10: `ovr_err` also clears on the next clock edge whenever `sio_en` is 0.
- R11: With `rx_en` low the receiver stays idle. A frame sent in that state raises no interrupt and leaves `rx_full` unchanged.
- R12: After reset, `rx_full`, `rx_irq`, every error flag and `buf_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial data line, idle high |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit period |
| sio_en | input | 1 | Serial port enable |
| rx_en | input | 1 | Receive enable |
| cfg_seven | input | 1 | 1: seven data bits, 0: eight |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_two_stop | input | 1 | Two stop bits |
| rd_buf | input | 1 | Buffer read strobe |
| wr_stat | input | 1 | Status register write strobe |
| buf_data | output | 8 | Receive buffer register |
| rx_full | output | 1 | Receive buffer full flag |
| par_err | output | 1 | Parity error flag |
| frm_err | output | 1 | Framing error flag |
| ovr_err | output | 1 | Overrun error flag |
| sum_err | output | 1 | Summary error flag |
| rx_irq | output | 1 | Receive interrupt request pulse |

## Verification
The word, `rx_full`, the interrupt pulse and the parity and framing flags all become due together, on the 8th oversample tick after the first stop bit is driven. The input synchroniser can shift this by at most one tick. The scoreboard monitor pops the expected word at the interrupt and checks that the tick distance from the start of the stop bit lies within 7 to 9. Flag clears, buffer reads and enable changes take effect on the next clock edge, so the bench samples them on the falling edge of the clock after the strobe is removed. Cases that must produce no word (glitch, disabled receiver, overrun) are checked as unexpected interrupts with an empty queue, and through the flags and `rx_full` once the frame has finished.

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       baud_tick,
  input  logic       sio_en,
  input  logic       rx_en,
  input  logic       cfg_seven,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       rd_buf,
  input  logic       wr_stat,
  output logic [7:0] buf_data,
  output logic       rx_full,
  output logic       par_err,
  output logic       frm_err,
  output logic       ovr_err,
  output logic       sum_err,
  output logic       rx_irq
);
  localparam int CW   = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int HALF = OSR / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [7:0]    sh;
  logic          acc, pbit;
  logic          rx_s1, rx_s2, rx_q;

  logic       rx_on, fall, mid, done, take, lost, par_bad, clr_err;
  logic [2:0] last;
  logic [7:0] word;

  assign rx_on   = sio_en & rx_en;
  assign fall    = rx_q & ~rx_s2;
  assign mid     = baud_tick && (cnt == CW'(HALF - 1));
  assign done    = rx_on && mid && (st == S_STOP1);
  assign take    = done && (!rx_full || rd_buf);
  assign lost    = done && rx_full && !rd_buf;
  assign last    = cfg_seven ? 3'd6 : 3'd7;
  assign word    = cfg_seven ? {1'b0, sh[7:1]} : sh;
  assign par_bad = cfg_par_en && (acc ^ pbit ^ cfg_par_odd);
  assign clr_err = wr_stat || !rx_en;
  assign sum_err = par_err | frm_err | ovr_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
      rx_q  <= 1'b1;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
      rx_q  <= rx_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bidx <= '0;
      sh   <= '0;
      acc  <= 1'b0;
      pbit <= 1'b0;
    end else if (!rx_on) begin
      st <= S_IDLE;
    end else if (st == S_IDLE) begin
      if (fall) begin
        st  <= S_START;
        cnt <= '0;
      end
    end else if (baud_tick) begin
      cnt <= (cnt == CW'(OSR - 1)) ? '0 : cnt + 1'b1;
      if (mid) begin
        case (st)
          S_START: begin
            if (rx_s2) st <= S_IDLE;
            else begin
              st   <= S_DATA;
              bidx <= '0;
              acc  <= 1'b0;
            end
          end
          S_DATA: begin
            sh   <= {rx_s2, sh[7:1]};
            acc  <= acc ^ rx_s2;
            bidx <= bidx + 1'b1;
            if (bidx == last) st <= cfg_par_en ? S_PAR : S_STOP1;
          end
          S_PAR: begin
            pbit <= rx_s2;
            st   <= S_STOP1;
          end
          S_STOP1: st <= cfg_two_stop ? S_STOP2 : S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_data <= '0;
      rx_full  <= 1'b0;
      rx_irq   <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      ovr_err  <= 1'b0;
    end else begin
      rx_irq <= take;
      if (take) begin
        buf_data <= word;
        rx_full  <= 1'b1;
      end else if (rd_buf) begin
        rx_full <= 1'b0;
      end
      if (done && par_bad) par_err <= 1'b1;
      else if (clr_err)    par_err <= 1'b0;
      if (done && !rx_s2)  frm_err <= 1'b1;
      else if (clr_err)    frm_err <= 1'b0;
      if (lost)                     ovr_err <= 1'b1;
      else if (clr_err || !sio_en)  ovr_err <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sio_en,
  input logic       rx_en,
  input logic       rd_buf,
  input logic       wr_stat,
  input logic [7:0] buf_data,
  input logic       rx_full,
  input logic       par_err,
  input logic       ovr_err,
  input logic       rx_irq
);
  // R3
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
  // R3
  irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full);
  // R3
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> rx_irq);
  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_buf |=> (!rx_full || rx_irq));
  // R7
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> ($stable(buf_data) && rx_full && !rx_irq));
  // R9
  par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && rx_en && !wr_stat) |=> par_err);
  // R9
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!par_err && !ovr_err));
  // R10
  sio_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sio_en |=> !ovr_err);
  // R11
  idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_irq);
endmodule

bind uart_rx_status uart_rx_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sio_en(sio_en), .rx_en(rx_en),
  .rd_buf(rd_buf), .wr_stat(wr_stat), .buf_data(buf_data),
  .rx_full(rx_full), .par_err(par_err), .ovr_err(ovr_err), .rx_irq(rx_irq)
);

// File: tb/tb_uart_rx_status.sv
module tb_uart_rx_status;
  logic clk = 0, rst_n = 0, rxd = 1, baud_tick = 0;
  logic sio_en = 1, rx_en = 1, cfg_seven = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0;
  logic rd_buf = 0, wr_stat = 0;
  logic [7:0] buf_data;
  logic rx_full, par_err, frm_err, ovr_err, sum_err, rx_irq;

  uart_rx_status dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
    .sio_en(sio_en), .rx_en(rx_en), .cfg_seven(cfg_seven), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop), .rd_buf(rd_buf),
    .wr_stat(wr_stat), .buf_data(buf_data), .rx_full(rx_full), .par_err(par_err),
    .frm_err(frm_err), .ovr_err(ovr_err), .sum_err(sum_err), .rx_irq(rx_irq)
  );

  always #10 clk = ~clk;

  int div = 0;
  int tick_cnt = 0;
  int stop_mark = 0;
  always @(negedge clk) begin
    div <= (div + 1) % 4;
    baud_tick <= (div == 3);
  end
  always @(posedge clk) if (baud_tick) tick_cnt <= tick_cnt + 1;

  typedef struct { logic [7:0] d; logic pe; logic fe; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit m_pe = 0, m_fe = 0;
  bit done_flag = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic prev_irq = 0;
  always @(negedge clk) begin
    prev_irq <= rx_irq;
    if (rst_n && prev_irq && rx_irq) chk("R3", "irq longer than one cycle", 1, 0);
    if (rst_n && rx_irq) begin
      if (q.size() == 0) chk("R11", "unexpected irq", 1, 0);
      else begin
        exp_t e;
        int dt;
        e = q.pop_front();
        dt = tick_cnt - stop_mark;
        chk("R2", "buffer word", buf_data, e.d);
        chk("R4", "parity flag", par_err, e.pe);
        chk("R5", "framing flag", frm_err, e.fe);
        chk("R3", "full at irq", rx_full, 1);
        chk("R3", "irq at mid stop (tick 7..9)", (dt >= 7 && dt <= 9), 1);
      end
    end
  end

  task automatic bit_out(input logic b);
    int mark;
    rxd = b;
    mark = tick_cnt;
    wait (tick_cnt == mark + 16);
    @(negedge clk);
  endtask

  task automatic idle_ticks(input int n);
    int mark;
    mark = tick_cnt;
    wait (tick_cnt == mark + n);
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop, input bit expect_irq);
    int n;
    logic ones, pb;
    exp_t e;
    n = cfg_seven ? 7 : 8;
    ones = cfg_seven ? ^d[6:0] : ^d;
    pb = cfg_par_odd ? ~ones : ones;
    if (bad_par) pb = ~pb;
    if (expect_irq) begin
      e.d  = cfg_seven ? {1'b0, d[6:0]} : d;
      e.pe = m_pe | (cfg_par_en & bad_par);
      e.fe = m_fe | bad_stop;
      m_pe = e.pe;
      m_fe = e.fe;
      q.push_back(e);
    end
    bit_out(1'b0);
    for (int i = 0; i < n; i++) bit_out(d[i]);
    if (cfg_par_en) bit_out(pb);
    stop_mark = tick_cnt;
    bit_out(!bad_stop);
    if (cfg_two_stop) bit_out(1'b1);
    rxd = 1'b1;
    idle_ticks(4);
  endtask

  task automatic rd_pulse();
    @(negedge clk) rd_buf = 1;
    @(negedge clk) rd_buf = 0;
  endtask

  task automatic wr_pulse();
    @(negedge clk) wr_stat = 1;
    @(negedge clk) wr_stat = 0;
    m_pe = 0;
    m_fe = 0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #3ms;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R12", "reset full", rx_full, 0);
    chk("R12", "reset irq", rx_irq, 0);
    chk("R12", "reset flags", {par_err, frm_err, ovr_err, sum_err}, 0);
    chk("R12", "reset buffer", buf_data, 0);
    rst_n = 1;
    idle_ticks(4);

    send_frame(8'hA5, 0, 0, 1);
    chk("R3", "full after frame", rx_full, 1);
    rd_pulse();
    chk("R6", "full cleared by read", rx_full, 0);
    chk("R6", "buffer kept after read", buf_data, 8'hA5);

    send_frame(8'h3C, 0, 0, 1); rd_pulse();
    cfg_par_en = 1;
    send_frame(8'h96, 0, 0, 1); rd_pulse();
    cfg_par_odd = 1;
    send_frame(8'h01, 0, 0, 1); rd_pulse();
    cfg_par_odd = 0; cfg_seven = 1; cfg_two_stop = 1;
    send_frame(8'hD3, 0, 0, 1); rd_pulse();
    cfg_seven = 0; cfg_two_stop = 0;

    send_frame(8'h5A, 1, 0, 1);
    chk("R8", "summary with parity", sum_err, 1);
    rd_pulse();
    chk("R9", "parity kept after read", par_err, 1);
    send_frame(8'h11, 0, 0, 1); rd_pulse();
    wr_pulse();
    chk("R9", "parity cleared by status write", par_err, 0);
    chk("R8", "summary cleared", sum_err, 0);

    cfg_par_en = 0;
    send_frame(8'h42, 0, 1, 1);
    chk("R8", "summary with framing", sum_err, 1);
    rd_pulse();
    @(negedge clk) rx_en = 0;
    @(negedge clk) rx_en = 1;
    m_fe = 0;
    chk("R9", "framing cleared by rx_en low", frm_err, 0);

    rxd = 0; idle_ticks(3); rxd = 1; idle_ticks(24);
    chk("R1", "glitch gives no word", rx_full, 0);

    rx_en = 0;
    send_frame(8'hE7, 0, 0, 0);
    chk("R11", "disabled receiver keeps full low", rx_full, 0);
    rx_en = 1;
    idle_ticks(2);

    send_frame(8'h81, 0, 0, 1);
    send_frame(8'h7E, 0, 0, 0);
    chk("R7", "overrun flag", ovr_err, 1);
    chk("R8", "summary with overrun", sum_err, 1);
    chk("R7", "old word kept", buf_data, 8'h81);
    chk("R7", "full stays set", rx_full, 1);
    rd_pulse();
    chk("R7", "read returns old word", buf_data, 8'h81);
    chk("R6", "read clears full in overrun", rx_full, 0);
    chk("R9", "overrun kept after read", ovr_err, 1);
    wr_pulse();
    chk("R9", "overrun cleared by status write", ovr_err, 0);

    send_frame(8'h24, 0, 0, 1);
    send_frame(8'h99, 0, 0, 0);
    chk("R7", "second overrun", ovr_err, 1);
    @(negedge clk) sio_en = 0;
    @(negedge clk) sio_en = 1;
    chk("R10", "overrun cleared by sio_en low", ovr_err, 0);
    rd_pulse();

    send_frame(8'hC3, 0, 0, 1);
    chk("R7", "transfer resumes after overrun", buf_data, 8'hC3);
    rd_pulse();

    chk("R3", "all expected words delivered", q.size(), 0);
    finish_run();
  end
endmodule